// File: doc/BRIEF.md
# Endian-Aware Byte-Lane Steering Unit

This block sits between a 32-bit system data bus and the operand side of a master or slave port. A request gives a start address, a transfer size (byte, halfword or word), an endianness mode and a beat count. The unit accepts the request with a valid/ready handshake and then produces one beat per cycle while downstream is ready. For each beat it outputs the beat address and a per-lane active mask. It also places a right-aligned write operand onto the bus lanes that the beat uses, and it pulls the read bytes off those lanes into a right-aligned, zero-filled operand.

Three byte orderings are supported. Little-endian and byte-invariant big-endian light the same physical lanes and differ only in which of those lanes carries the most significant byte. Word-invariant big-endian mirrors the lane numbering inside the word, so a given byte address uses a different lane. In a narrow burst the address advances by the transfer size on every accepted beat, so the active lanes move from beat to beat. A request whose address is not aligned to its size does not start a burst. It produces a single error beat instead.

Top module: `bytelane_router`

## Requirements
- R1: Mode code 2'b00 (little-endian): the element byte of significance k sits on lane (offset + k), where offset is beatAddr[1:0] and lane L is bits [8L+7:8L]. So a byte at offset N uses lane N, a halfword at offset 0 uses lanes 1:0 with its MS byte on lane 1, a halfword at offset 2 uses lanes 3:2, and a word uses all lanes with its MS byte on lane 3.
- R2: Mode code 2'b01 (byte-invariant big-endian) activates the same lanes as R1 for every size and offset, but the MS byte of a multi-byte element sits on the lowest-addressed lane of the group.
- R3: Mode code 2'b10 (word-invariant big-endian): the byte at address offset N uses lane 3-N. For halfwords and words, the MS byte goes to the transfer address and less significant bytes go to rising addresses. So a halfword at offset 0 uses lanes 3:2 with its MS byte on lane 3.
- R4: Mode code 2'b11 behaves as little-endian. Size codes are 2'b00 byte, 2'b01 halfword and 2'b10 word, and size code 2'b11 behaves as a word.
- R5: wrBus carries the operand bytes on the active lanes and zero on every inactive lane. It is all zero when no valid, aligned beat is present.
- R6: rdOperand holds the bytes read from the active lanes, right-aligned in significance order, with all higher bits zero. It is all zero when no valid, aligned beat is present.
- R7: A request whose offset is not a multiple of the size in bytes produces exactly one beat, with alignErr high, laneMask zero and beatLast high. This beat lasts one cycle whatever beatReady is, and the unit is idle on the next cycle.
- R8: reqReady is high only while no beat is pending. A request is accepted when reqValid and reqReady are both high at a clock edge, and its first beat is presented on the next cycle with beatAddr equal to the start address.
- R9: When beatValid and beatReady are both high at a clock edge on a non-final beat, the next beat's address is the old address plus the size in bytes. While beatReady is low, the beat's address and lane mask hold.
- R10: A burst has reqLen+1 beats. beatLast is high only on the final beat, and the unit is idle on the cycle after the final beat completes.
- R11: After reset, reqReady is 1 and beatValid, alignErr and laneMask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request present |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | 32 | Start address |
| reqSize | input | 2 | Transfer size code |
| reqMode | input | 2 | Endianness mode code |
| reqLen | input | 8 | Beat count minus one |
| beatValid | output | 1 | A beat is presented |
| beatReady | input | 1 | Downstream takes the beat |
| beatLast | output | 1 | Presented beat is the final one |
| beatAddr | output | 32 | Address of the presented beat |
| laneMask | output | 4 | Active byte lanes, bit L for bits [8L+7:8L] |
| alignErr | output | 1 | Misaligned request, single error beat |
| wrOperand | input | 32 | Right-aligned write operand |
| wrBus | output | 32 | Write data steered onto bus lanes |
| rdBus | input | 32 | Read data from the bus lanes |
| rdOperand | output | 32 | Right-aligned, zero-filled read operand |

## Verification
The properties assume that rstN is held low across at least one rising edge before activity begins, and that every input carries a defined value at each edge. The request fields may change freely except at the acceptance edge, and beatReady may toggle in any pattern. The stimulus therefore drives every input on the falling edge with defined values only. It puts random values on the request fields while no request is pending, and it keeps reqValid and its fields steady until the acceptance edge. It randomises beatReady so that stalls and advances interleave, and it holds beatReady low through the misaligned cases.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

  typedef enum logic [1:0] {
    MODE_LE = 2'b00,
    MODE_BI = 2'b01,
    MODE_WI = 2'b10
  } laneMode_e;

  typedef struct packed {
    logic      active;
    logic [1:0] size;
    laneMode_e mode;
  } beatCtl_t;

endpackage

// File: rtl/bytelane_ctrl.sv
module bytelane_ctrl
  import bytelane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqMode,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              beatValid,
  input  logic              beatReady,
  output logic              beatLast,
  output logic              alignErr,
  output logic [ADDR_W-1:0] beatAddr,
  output beatCtl_t          beatCtl
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FAULT} state_e;

  state_e            state;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  laneMode_e         modeQ;
  logic [LEN_W-1:0]  remQ;

  logic [1:0]        sizeNorm;
  laneMode_e         modeNorm;
  logic [OFF_W-1:0]  alignMask;
  logic              misaligned;
  logic              accept;

  always_comb begin
    sizeNorm   = (int'(reqSize) > OFF_W) ? 2'(OFF_W) : reqSize;
    modeNorm   = (reqMode == 2'b11) ? MODE_LE : laneMode_e'(reqMode);
    alignMask  = OFF_W'((1 << sizeNorm) - 1);
    misaligned = (reqAddr[OFF_W-1:0] & alignMask) != '0;
    accept     = reqValid && reqReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      addrQ <= '0;
      sizeQ <= '0;
      modeQ <= MODE_LE;
      remQ  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          addrQ <= reqAddr;
          sizeQ <= sizeNorm;
          modeQ <= modeNorm;
          remQ  <= reqLen;
          state <= misaligned ? ST_FAULT : ST_RUN;
        end
        ST_RUN: if (beatReady) begin
          if (remQ == '0) begin
            state <= ST_IDLE;
          end else begin
            addrQ <= addrQ + (ADDR_W'(1) << sizeQ);
            remQ  <= remQ - LEN_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    beatValid      = (state != ST_IDLE);
    alignErr       = (state == ST_FAULT);
    beatLast       = (state == ST_FAULT) || ((state == ST_RUN) && (remQ == '0));
    beatAddr       = addrQ;
    beatCtl.active = (state == ST_RUN);
    beatCtl.size   = sizeQ;
    beatCtl.mode   = modeQ;
  end

endmodule

// File: rtl/bytelane_dp.sv
module bytelane_dp
  import bytelane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = 2
) (
  input  beatCtl_t          ctl,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] wrOperand,
  input  logic [DATA_W-1:0] rdBus,
  output logic [LANES-1:0]  laneMask,
  output logic [DATA_W-1:0] wrBus,
  output logic [DATA_W-1:0] rdOperand
);

  int nBytes;
  int off;
  int lane;

  always_comb begin
    laneMask  = '0;
    wrBus     = '0;
    rdOperand = '0;
    nBytes    = 1 << ctl.size;
    off       = int'(offset);
    lane      = 0;
    if (ctl.active) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < nBytes) begin
          unique case (ctl.mode)
            MODE_BI: lane = off + nBytes - 1 - k;
            MODE_WI: lane = LANES - off - nBytes + k;
            default: lane = off + k;
          endcase
          for (int l = 0; l < LANES; l++) begin
            if (lane == l) begin
              laneMask[l]        = 1'b1;
              wrBus[8*l +: 8]    = wrOperand[8*k +: 8];
              rdOperand[8*k +: 8] = rdBus[8*l +: 8];
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/bytelane_router.sv
module bytelane_router
  import bytelane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqMode,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              beatValid,
  input  logic              beatReady,
  output logic              beatLast,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [DATA_W/8-1:0] laneMask,
  output logic              alignErr,
  input  logic [DATA_W-1:0] wrOperand,
  output logic [DATA_W-1:0] wrBus,
  input  logic [DATA_W-1:0] rdBus,
  output logic [DATA_W-1:0] rdOperand
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  beatCtl_t beatCtl;

  bytelane_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqMode(reqMode), .reqLen(reqLen),
    .beatValid(beatValid), .beatReady(beatReady), .beatLast(beatLast),
    .alignErr(alignErr), .beatAddr(beatAddr), .beatCtl(beatCtl)
  );

  bytelane_dp #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) dp_i (
    .ctl(beatCtl), .offset(beatAddr[OFF_W-1:0]),
    .wrOperand(wrOperand), .rdBus(rdBus),
    .laneMask(laneMask), .wrBus(wrBus), .rdOperand(rdOperand)
  );

endmodule

// File: rtl/bytelane_chk.sv
module bytelane_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              beatValid,
  input logic              beatReady,
  input logic              beatLast,
  input logic              alignErr,
  input logic [LANES-1:0]  laneMask,
  input logic [DATA_W-1:0] wrBus,
  input logic [DATA_W-1:0] rdOperand,
  input logic [ADDR_W-1:0] beatAddr,
  input logic [1:0]        beatSize
);

  // R1 R2 R3: a good beat lights as many lanes as the size has bytes
  assert_lane_count_R1: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !alignErr |-> $countones(laneMask) == (1 << beatSize));

  // R5: inactive lanes of the write bus stay zero
  for (genvar g = 0; g < LANES; g++) begin : gIdleLane
    assert_idle_lane_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
      !laneMask[g] |-> wrBus[8*g +: 8] == 8'h00);
  end

  // R6: read operand is zero above the element width
  assert_read_zero_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !alignErr |-> (rdOperand >> (8 << beatSize)) == '0);

  // R7: error beat carries no lanes, is final, lasts one cycle
  assert_fault_shape_R7: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> beatValid && beatLast && laneMask == '0);
  assert_fault_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> !alignErr && !beatValid);

  // R8: acceptance leads to a beat, and no acceptance while a beat is pending
  assert_accept_beat_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> beatValid && !reqReady);
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> !reqReady);

  // R9: stall holds, advance steps by the size
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReady && !alignErr |=> beatValid && $stable(beatAddr) && $stable(laneMask));
  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatReady && !beatLast && !alignErr |=>
      beatValid && (beatAddr - $past(beatAddr)) == (ADDR_W'(1) << $past(beatSize)));

  // R10: final beat taken leaves the unit idle
  assert_last_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatReady && beatLast |=> !beatValid && reqReady);

endmodule

bind bytelane_router bytelane_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .beatValid(beatValid), .beatReady(beatReady), .beatLast(beatLast),
  .alignErr(alignErr), .laneMask(laneMask), .wrBus(wrBus),
  .rdOperand(rdOperand), .beatAddr(beatAddr), .beatSize(beatCtl.size)
);

// File: tb/bytelane_router_tb_top.sv
module bytelane_router_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqAddr;
  logic [1:0]  reqSize;
  logic [1:0]  reqMode;
  logic [7:0]  reqLen;
  logic        beatValid;
  logic        beatReady;
  logic        beatLast;
  logic [31:0] beatAddr;
  logic [3:0]  laneMask;
  logic        alignErr;
  logic [31:0] wrOperand;
  logic [31:0] wrBus;
  logic [31:0] rdBus;
  logic [31:0] rdOperand;

  always #10 clk = ~clk;

  bytelane_router dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqMode(reqMode), .reqLen(reqLen),
    .beatValid(beatValid), .beatReady(beatReady), .beatLast(beatLast),
    .beatAddr(beatAddr), .laneMask(laneMask), .alignErr(alignErr),
    .wrOperand(wrOperand), .wrBus(wrBus), .rdBus(rdBus), .rdOperand(rdOperand)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // reference model state
  bit          mBusy, mErr, mOdd, accepted;
  logic [31:0] mAddr;
  int          mSize, mMode, mRem;
  int          readyPct;
  bit          sampReady, sampReqV;

  // pending request
  bit          pV;
  logic [31:0] pA;
  logic [1:0]  pS, pM;
  logic [7:0]  pL;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Memory-address view: element byte k lives at a memory address, and the
  // memory address picks the lane.
  task automatic refBeat(input logic [31:0] a, input int sz, input int md,
                         input logic [31:0] wop, input logic [31:0] rbus,
                         output logic [3:0] m, output logic [31:0] wb, output logic [31:0] ro);
    int n;
    int off;
    int memA;
    int ln;
    n = 1 << sz;
    off = int'(a[1:0]);
    m = '0; wb = '0; ro = '0;
    for (int k = 0; k < n; k++) begin
      memA = (md == 0) ? off + k : off + n - 1 - k;
      ln   = (md == 2) ? 3 - memA : memA;
      m[ln] = 1'b1;
      wb[8*ln +: 8] = wop[8*k +: 8];
      ro[8*k +: 8]  = rbus[8*ln +: 8];
    end
  endtask

  task automatic step();
    logic [3:0]  em;
    logic [31:0] ew, er;
    string       mt;
    @(negedge clk);
    wrOperand = $urandom;
    rdBus     = $urandom;
    beatReady = ($urandom_range(99) < readyPct);
    reqValid  = pV;
    reqAddr   = pV ? pA : $urandom;
    reqSize   = pV ? pS : 2'($urandom);
    reqMode   = pV ? pM : 2'($urandom);
    reqLen    = pV ? pL : 8'($urandom);
    #2;
    em = '0; ew = '0; er = '0;
    if (mBusy) refBeat(mAddr, mSize, mMode, wrOperand, rdBus, em, ew, er);
    mt = mOdd ? "R4" : (mMode == 0 ? "R1" : (mMode == 1 ? "R2" : "R3"));
    if (mErr) mt = "R7";
    chk("R8", "reqReady", 32'(reqReady), 32'(!(mBusy || mErr)));
    chk("R8", "beatValid", 32'(beatValid), 32'(mBusy || mErr));
    chk(mt, "laneMask", 32'(laneMask), 32'(em));
    chk("R5", "wrBus", wrBus, ew);
    chk("R6", "rdOperand", rdOperand, er);
    chk("R7", "alignErr", 32'(alignErr), 32'(mErr));
    if (mBusy || mErr) begin
      chk("R9", "beatAddr", beatAddr, mAddr);
      chk("R10", "beatLast", 32'(beatLast), 32'(mErr || (mBusy && mRem == 0)));
    end
    sampReady = beatReady;
    sampReqV  = reqValid;
    @(posedge clk);
    if (mErr) begin
      mErr = 1'b0;
    end else if (mBusy) begin
      if (sampReady) begin
        if (mRem == 0) mBusy = 1'b0;
        else begin
          mAddr = mAddr + (32'd1 << mSize);
          mRem  = mRem - 1;
        end
      end
    end else if (sampReqV) begin
      accepted = 1'b1;
      mSize = (pS == 2'b11) ? 2 : int'(pS);
      mMode = (pM == 2'b11) ? 0 : int'(pM);
      mOdd  = (pS == 2'b11) || (pM == 2'b11);
      mAddr = pA;
      mRem  = int'(pL);
      if ((int'(pA[1:0]) % (1 << mSize)) != 0) mErr = 1'b1;
      else mBusy = 1'b1;
    end
  endtask

  task automatic burst(input logic [31:0] a, input logic [1:0] s, input logic [1:0] m, input int len);
    pA = a; pS = s; pM = m; pL = 8'(len); pV = 1'b1;
    accepted = 1'b0;
    while (!accepted) step();
    pV = 1'b0;
    while (mBusy || mErr) step();
    step();
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    mBusy = 0; mErr = 0; mOdd = 0; accepted = 0;
    mAddr = '0; mSize = 0; mMode = 0; mRem = 0;
    pV = 0; pA = '0; pS = '0; pM = '0; pL = '0;
    readyPct = 100;
    rstN = 1'b0; reqValid = 0; reqAddr = '0; reqSize = '0; reqMode = '0; reqLen = '0;
    beatReady = 0; wrOperand = '0; rdBus = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R11 reset state
    chk("R11", "reqReady", 32'(reqReady), 32'd1);
    chk("R11", "beatValid", 32'(beatValid), 32'd0);
    chk("R11", "alignErr", 32'(alignErr), 32'd0);
    chk("R11", "laneMask", 32'(laneMask), 32'd0);

    // single beats: every mode, size and aligned offset (R1 R2 R3 R4)
    for (int md = 0; md < 4; md++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++) begin
          int szEff;
          szEff = (sz == 3) ? 2 : sz;
          if ((off % (1 << szEff)) == 0)
            burst(32'h1000 + 32'(off) + 32'(md * 16), 2'(sz), 2'(md), 0);
        end

    // misaligned requests with downstream stalled (R7)
    readyPct = 0;
    burst(32'h0000_0101, 2'b01, 2'b00, 2);
    burst(32'h0000_0102, 2'b10, 2'b10, 0);
    burst(32'h0000_0103, 2'b01, 2'b01, 5);
    burst(32'h0000_0201, 2'b11, 2'b11, 1);

    // narrow bursts with random stalls (R9 R10)
    readyPct = 60;
    for (int md = 0; md < 3; md++) begin
      burst(32'h0000_0200, 2'b00, 2'(md), 7);
      burst(32'h0000_0202, 2'b01, 2'(md), 5);
      burst(32'h0000_0300, 2'b10, 2'(md), 3);
    end
    burst(32'h0000_0400, 2'b11, 2'b11, 2);
    burst(32'hFFFF_FFFC, 2'b00, 2'b10, 7);
    readyPct = 100;
    burst(32'h0000_0501, 2'b00, 2'b01, 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule